// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block holds the two programmable dividers of a frequency synthesizer's digital section. A reference counter divides the reference clock by a ratio R. A main counter divides the VCO-side clock by a ratio N. Each divider issues a one-cycle pulse every time its count wraps.

In single mode the main counter alone sets the division. In dual mode the main counter counts output cycles of an external two-ratio prescaler. A modulus-control output asks that prescaler for its alternate ratio during the first A cycles of every N-cycle period, so that A cycles are swallowed per period. A mode bit picks whether the modulus-control line moves on the rising or the falling edge of the VCO-side clock. A standby input parks both counters.

New ratios are written through a load strobe and can be applied in two ways. In asynchronous acquisition they take effect at once. In synchronous acquisition they are staged and applied only when each divider wraps, so that a counter never runs a period with a mixture of old and new ratios. The load strobe and mode inputs must be valid with respect to both clocks.

Top module: `pswallow_div`

## Requirements
- R1: With `dual_i`=0, `vco_div_o` is high for exactly one cycle every N VCO-clock cycles, and `mod_o` stays low. The first pulse appears N rising edges after counting starts.
- R2: With `dual_i`=1 and `mod_edge_i`=0, `mod_o` is high during the first min(A,N) cycles of each N-cycle period and low for the rest of it. The period's first cycle is the cycle in which `vco_div_o` pulses. With A=0, `mod_o` stays low.
- R3: With `mod_edge_i`=1, `mod_o` carries the same sequence as in R2, but each change takes place on the falling edge that follows the rising edge at which it would occur with `mod_edge_i`=0.
- R4: An A value larger than N is treated as N, so `mod_o` stays high through the whole period in dual mode.
- R5: `ref_div_o` is high for exactly one cycle every R reference-clock cycles. The first pulse appears R rising edges after counting starts.
- R6: A ratio value of 0 for R or N acts as 1, so the output pulses on every cycle. The A clamp of R4 then limits A to 1.
- R7: With `sync_i`=1, a rising edge at which `load_i` is high only stages the ratio inputs. The running period completes with the old ratio, and the staged value takes over at the wrap. A load that falls on a wrap edge is applied at that edge.
- R8: With `sync_i`=0, a rising edge at which `load_i` is high makes the input ratios active at that edge and restarts the counter from zero. No pulse is issued on that edge.
- R9: While `standby_i` is high, both counters are held at zero. From the next rising edge `ref_div_o`, `vco_div_o` and `mod_o` are low. After release, counting resumes from zero as in R1 and R5.
- R10: While `rst_ni` is low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock |
| vco_clk_i | input | 1 | VCO-side clock (prescaler output in dual mode) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Parks both counters and forces outputs low |
| dual_i | input | 1 | 1: A/N swallow mode, 0: plain divide-by-N |
| sync_i | input | 1 | 1: apply loaded ratios at the wrap, 0: apply at once |
| mod_edge_i | input | 1 | 0: modulus control moves on rising edge, 1: on falling edge |
| load_i | input | 1 | Ratio load strobe, sampled on rising edges of both clocks |
| r_ratio_i | input | RW | Reference division ratio R |
| n_ratio_i | input | NW | Main division ratio N |
| a_ratio_i | input | AW | Swallow count A |
| ref_div_o | output | 1 | Divided reference pulse |
| vco_div_o | output | 1 | Divided VCO pulse |
| mod_o | output | 1 | Modulus control to the external prescaler |

## Verification
The bench builds the block with RW=6, NW=6 and AW=4. With these widths, A values above N (for example A=7 against N=3) can be written, so the clamp is exercised. All periods stay short, so every ratio change, wrap-coincident load and standby entry falls within a few dozen cycles of a scoreboard run. Both clock inputs are fed from one bench clock. This keeps the expected pulse positions of the two dividers on one sample grid, and it makes a load that coincides with a reference wrap but not with a VCO wrap easy to set up.

// File: rtl/pswallow_div_pkg.sv
package pswallow_div_pkg;
  typedef enum logic {
    MOD_EDGE_RISE = 1'b0,
    MOD_EDGE_FALL = 1'b1
  } mod_edge_e;
endpackage

// File: rtl/pdiv_ratio_stage.sv
module pdiv_ratio_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  input  logic         load_i,
  input  logic         sync_i,
  input  logic         wrap_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] act_nxt_o
);
  logic [W-1:0] act_q, stg_q;
  logic         pend_q;

  // load at a wrap edge bypasses the stage
  always_comb begin
    act_nxt_o = act_q;
    if (load_i && (!sync_i || wrap_i)) act_nxt_o = val_i;
    else if (wrap_i && pend_q)         act_nxt_o = stg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      stg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      act_q <= act_nxt_o;
      if (load_i && sync_i && !wrap_i) begin
        stg_q  <= val_i;
        pend_q <= 1'b1;
      end else if (wrap_i || (load_i && !sync_i)) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pdiv_wrap_counter.sv
module pdiv_wrap_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         restart_i,
  input  logic [W-1:0] eff_i,
  output logic [W-1:0] cnt_nxt_o,
  output logic         wrap_o,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic         pulse_q;

  assign wrap_o = !hold_i && (cnt_q == eff_i - W'(1));

  always_comb begin
    if (hold_i || restart_i || wrap_o) cnt_nxt_o = '0;
    else                               cnt_nxt_o = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt_o;
      pulse_q <= wrap_o && !restart_i;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/pdiv_modulus_ctrl.sv
module pdiv_modulus_ctrl
  import pswallow_div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         dual_i,
  input  mod_edge_e    edge_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] a_lim_nxt_i,
  output logic         mod_o
);
  logic mod_rise_q, mod_fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_rise_q <= 1'b0;
    else         mod_rise_q <= !hold_i && dual_i && (cnt_nxt_i < a_lim_nxt_i);
  end

  // half-cycle retimed copy
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_fall_q <= 1'b0;
    else         mod_fall_q <= mod_rise_q;
  end

  assign mod_o = (edge_i == MOD_EDGE_FALL) ? mod_fall_q : mod_rise_q;
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_div_pkg::*;
#(
  parameter int RW = 12,
  parameter int NW = 10,
  parameter int AW = 7
) (
  input  logic          ref_clk_i,
  input  logic          vco_clk_i,
  input  logic          rst_ni,
  input  logic          standby_i,
  input  logic          dual_i,
  input  logic          sync_i,
  input  logic          mod_edge_i,
  input  logic          load_i,
  input  logic [RW-1:0] r_ratio_i,
  input  logic [NW-1:0] n_ratio_i,
  input  logic [AW-1:0] a_ratio_i,
  output logic          ref_div_o,
  output logic          vco_div_o,
  output logic          mod_o
);
  logic          restart;
  logic [RW-1:0] r_act, r_act_nxt, r_eff, r_cnt_nxt;
  logic          r_wrap;
  logic [NW-1:0] n_act, n_act_nxt, n_eff, n_eff_nxt, n_cnt_nxt;
  logic [AW-1:0] a_act, a_act_nxt;
  logic [NW-1:0] a_lim, a_lim_nxt;
  logic          n_wrap;
  mod_edge_e     mod_edge;

  assign restart  = load_i && !sync_i;
  assign mod_edge = mod_edge_e'(mod_edge_i);

  // reference domain
  pdiv_ratio_stage #(.W(RW)) u_r_stage (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .val_i(r_ratio_i), .load_i(load_i),
    .sync_i(sync_i), .wrap_i(r_wrap), .act_o(r_act), .act_nxt_o(r_act_nxt)
  );

  assign r_eff = (r_act == '0) ? RW'(1) : r_act;

  pdiv_wrap_counter #(.W(RW)) u_r_cnt (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .hold_i(standby_i), .restart_i(restart),
    .eff_i(r_eff), .cnt_nxt_o(r_cnt_nxt), .wrap_o(r_wrap), .pulse_o(ref_div_o)
  );

  // vco domain
  pdiv_ratio_stage #(.W(NW)) u_n_stage (
    .clk_i(vco_clk_i), .rst_ni(rst_ni), .val_i(n_ratio_i), .load_i(load_i),
    .sync_i(sync_i), .wrap_i(n_wrap), .act_o(n_act), .act_nxt_o(n_act_nxt)
  );

  pdiv_ratio_stage #(.W(AW)) u_a_stage (
    .clk_i(vco_clk_i), .rst_ni(rst_ni), .val_i(a_ratio_i), .load_i(load_i),
    .sync_i(sync_i), .wrap_i(n_wrap), .act_o(a_act), .act_nxt_o(a_act_nxt)
  );

  assign n_eff     = (n_act == '0)     ? NW'(1) : n_act;
  assign n_eff_nxt = (n_act_nxt == '0) ? NW'(1) : n_act_nxt;
  assign a_lim     = (NW'(a_act) > n_eff)         ? n_eff     : NW'(a_act);
  assign a_lim_nxt = (NW'(a_act_nxt) > n_eff_nxt) ? n_eff_nxt : NW'(a_act_nxt);

  pdiv_wrap_counter #(.W(NW)) u_n_cnt (
    .clk_i(vco_clk_i), .rst_ni(rst_ni), .hold_i(standby_i), .restart_i(restart),
    .eff_i(n_eff), .cnt_nxt_o(n_cnt_nxt), .wrap_o(n_wrap), .pulse_o(vco_div_o)
  );

  pdiv_modulus_ctrl #(.W(NW)) u_mod (
    .clk_i(vco_clk_i), .rst_ni(rst_ni), .hold_i(standby_i), .dual_i(dual_i),
    .edge_i(mod_edge), .cnt_nxt_i(n_cnt_nxt), .a_lim_nxt_i(a_lim_nxt), .mod_o(mod_o)
  );
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int RW = 12,
  parameter int NW = 10,
  parameter int AW = 7
) (
  input logic          ref_clk_i,
  input logic          vco_clk_i,
  input logic          rst_ni,
  input logic          standby_i,
  input logic          dual_i,
  input logic          sync_i,
  input logic          mod_edge_i,
  input logic          load_i,
  input logic [NW-1:0] n_ratio_i,
  input logic [AW-1:0] a_ratio_i,
  input logic          ref_div_o,
  input logic          vco_div_o,
  input logic          mod_o,
  input logic [NW-1:0] n_eff,
  input logic [RW-1:0] r_eff,
  input logic [NW-1:0] a_lim
);
  AST_VCO_STANDBY: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    standby_i |=> !vco_div_o); // R9
  AST_REF_STANDBY: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    standby_i |=> !ref_div_o); // R9
  AST_SINGLE_NO_MOD: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    (!dual_i && !mod_edge_i) |=> (mod_edge_i || !mod_o)); // R1
  AST_VCO_PULSE_SPACED: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    (vco_div_o && n_eff != NW'(1)) |=> !vco_div_o); // R1
  AST_REF_PULSE_SPACED: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (ref_div_o && r_eff != RW'(1)) |=> !ref_div_o); // R5
  AST_ASYNC_RESTART: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    (load_i && !sync_i) |=> !vco_div_o); // R8
  AST_MOD_PERIOD_START: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    (vco_div_o && $past(dual_i) && !mod_edge_i && a_lim != '0) |-> mod_o); // R2
  AST_FULL_SWALLOW: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    (load_i && !sync_i && !standby_i && dual_i && !mod_edge_i && n_ratio_i != '0
     && NW'(a_ratio_i) >= n_ratio_i) |=> (mod_edge_i || mod_o)); // R4
endmodule

bind pswallow_div pswallow_div_chk #(.RW(RW), .NW(NW), .AW(AW)) u_chk (
  .ref_clk_i(ref_clk_i), .vco_clk_i(vco_clk_i), .rst_ni(rst_ni),
  .standby_i(standby_i), .dual_i(dual_i), .sync_i(sync_i),
  .mod_edge_i(mod_edge_i), .load_i(load_i), .n_ratio_i(n_ratio_i),
  .a_ratio_i(a_ratio_i), .ref_div_o(ref_div_o), .vco_div_o(vco_div_o),
  .mod_o(mod_o), .n_eff(n_eff), .r_eff(r_eff), .a_lim(a_lim)
);

// File: tb/pswallow_div_test.sv
module pswallow_div_test;
  localparam int RW = 6;
  localparam int NW = 6;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic standby_i = 1'b1, dual_i = 1'b0, sync_i = 1'b0, mod_edge_i = 1'b0, load_i = 1'b0;
  logic [RW-1:0] r_ratio_i = '0;
  logic [NW-1:0] n_ratio_i = '0;
  logic [AW-1:0] a_ratio_i = '0;
  logic ref_div_o, vco_div_o, mod_o;

  always #2.5 clk = ~clk;

  pswallow_div #(.RW(RW), .NW(NW), .AW(AW)) uut (
    .ref_clk_i(clk), .vco_clk_i(clk), .rst_ni(rst_ni), .standby_i(standby_i),
    .dual_i(dual_i), .sync_i(sync_i), .mod_edge_i(mod_edge_i), .load_i(load_i),
    .r_ratio_i(r_ratio_i), .n_ratio_i(n_ratio_i), .a_ratio_i(a_ratio_i),
    .ref_div_o(ref_div_o), .vco_div_o(vco_div_o), .mod_o(mod_o)
  );

  typedef struct packed { logic v; logic r; logic m; } exp_t;
  exp_t  exp_q[$];
  string vtag_q[$];
  string rtag_q[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic check_bit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s got=%0b exp=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor: one expected item per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        string vt, rt;
        it = exp_q.pop_front();
        vt = vtag_q.pop_front();
        rt = rtag_q.pop_front();
        check_bit(vt, "vco_div_o", vco_div_o, it.v);
        check_bit(vt, "mod_o", mod_o, it.m);
        check_bit(rt, "ref_div_o", ref_div_o, it.r);
      end
    end
  end

  task automatic push_item(logic v, logic r, logic m, string vt, string rt);
    exp_q.push_back('{v: v, r: r, m: m});
    vtag_q.push_back(vt);
    rtag_q.push_back(rt);
  endtask

  // expected free-run samples k=1..cnt after standby release
  task automatic push_run(int n, int a, int r, bit dual, bit fall, int cnt, string vt, string rt);
    int ne, ae, re;
    ne = (n == 0) ? 1 : n;
    re = (r == 0) ? 1 : r;
    ae = (a > ne) ? ne : a;
    for (int k = 1; k <= cnt; k++) begin
      logic m;
      if (!dual) m = 1'b0;
      else if (fall) m = (k == 1) ? 1'b0 : (((k - 1) % ne) < ae);
      else m = ((k % ne) < ae);
      push_item((k % ne) == 0, (k % re) == 0, m, vt, rt);
    end
  endtask

  // load ratios under standby, then release; returns at release time (edge+2)
  task automatic prime(int n, int a, int r, bit dual, bit fall, bit sync);
    standby_i  = 1'b1;
    n_ratio_i  = NW'(n);
    a_ratio_i  = AW'(a);
    r_ratio_i  = RW'(r);
    sync_i     = 1'b0;
    load_i     = 1'b1;
    @(posedge clk); #2;
    load_i     = 1'b0;
    sync_i     = sync;
    dual_i     = dual;
    mod_edge_i = fall;
    @(posedge clk); #2;
    standby_i  = 1'b0;
  endtask

  task automatic wait_edges(int cnt);
    repeat (cnt) @(posedge clk);
    #2;
  endtask

  task automatic run_case(int n, int a, int r, bit dual, bit fall, int cnt, string vt, string rt);
    prime(n, a, r, dual, fall, 1'b0);
    push_run(n, a, r, dual, fall, cnt, vt, rt);
    wait_edges(cnt);
  endtask

  initial begin
    // R10: reset state
    #3;
    check_bit("R10", "vco_div_o", vco_div_o, 1'b0);
    check_bit("R10", "ref_div_o", ref_div_o, 1'b0);
    check_bit("R10", "mod_o", mod_o, 1'b0);
    @(posedge clk); #2;
    rst_ni = 1'b1;
    @(posedge clk); #2;

    run_case(4, 0, 3, 1'b0, 1'b0, 12, "R1", "R5");  // single mode
    run_case(5, 2, 6, 1'b1, 1'b0, 15, "R2", "R5");  // dual, rising
    run_case(5, 2, 6, 1'b1, 1'b1, 15, "R3", "R5");  // dual, falling
    run_case(3, 7, 4, 1'b1, 1'b0, 9,  "R4", "R5");  // A > N clamps
    run_case(4, 0, 2, 1'b1, 1'b0, 8,  "R2", "R5");  // A = 0
    run_case(0, 0, 0, 1'b1, 1'b0, 5,  "R6", "R6");  // zero ratios
    run_case(0, 5, 1, 1'b1, 1'b0, 5,  "R6", "R6");  // zero N, A limited to 1

    // R7: synchronous load at sample 3; vco wraps later, ref wraps on that edge
    prime(4, 0, 3, 1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= 16; k++)
      push_item(k == 4 || k == 10 || k == 16, k == 3 || k == 8 || k == 13, 1'b0, "R7", "R7");
    wait_edges(2);
    n_ratio_i = NW'(6);
    r_ratio_i = RW'(5);
    load_i    = 1'b1;
    wait_edges(1);
    load_i    = 1'b0;
    wait_edges(13);

    // R8: asynchronous load at sample 3 restarts both counters
    prime(4, 0, 3, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k <= 16; k++)
      push_item(k == 9 || k == 15, k == 8 || k == 13, 1'b0, "R8", "R8");
    wait_edges(2);
    n_ratio_i = NW'(6);
    r_ratio_i = RW'(5);
    load_i    = 1'b1;
    wait_edges(1);
    load_i    = 1'b0;
    wait_edges(13);

    // R9: standby entered after sample 5
    prime(4, 4, 3, 1'b1, 1'b0, 1'b0);
    for (int k = 1; k <= 10; k++)
      if (k <= 5) push_item(k == 4, k == 3, 1'b1, "R9", "R9");
      else        push_item(1'b0, 1'b0, 1'b0, "R9", "R9");
    wait_edges(5);
    standby_i = 1'b1;
    wait_edges(5);

    wait_edges(2);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule